// File: doc/BRIEF.md
# Tiered Link Error Recovery Sequencer

This block is the control core that brings a lockstep multi-channel memory link back into service after a CRC fault. When an error event arrives, either a locally detected link CRC error or a poison code returned by the far end, the sequencer freezes new traffic and waits for the outstanding-operation count to drain. It then sends a poison code downstream, sends an error acknowledge, and waits a fixed self-refresh settling time. After that, the link is treated as powered down and the repair step for the current tier runs.

The tier is chosen when the error is taken. A lone error gets a plain retry (tier 1). An error that follows earlier errors inside a sliding count window gets a fast re-initialisation of the failing channel (tier 2). An error that arrives shortly after a tier 2 repair removes that channel for good (tier 3). In tier 3 the remaining channels are slow-initialised and scrubbed, a service request is raised, and the block relies on the redundant channel from then on. Once a channel is degraded, any further error raises a fatal flag and recovery is not entered again.

Stores enter through a valid/ready handshake. Only one store is tracked at a time. `store_ready` is high only while the link runs normally and no store is waiting. A store transfers on a cycle where both `store_valid` and `store_ready` are high, and the source must hold `store_valid` until then. A store retires only after a quiet window with no poison code. All other pins are plain level or pulse signals.

Top module: `link_recovery_seq`

## Requirements
- R1: After reset, every output is low except `store_ready`, which is high. `tier` reads 0 and `degraded_mask` reads 0.
- R2: An error event (`link_err` or `poison_rx`) taken during normal running raises `halt` from the next cycle. `halt` stays high while `outstanding` is non-zero and until recovery ends.
- R3: Once a sampled `outstanding` of zero ends the drain, `poison_tx` is high for exactly one cycle. `err_ack` is high for exactly the following cycle.
- R4: After the acknowledge, the block waits exactly SR_WAIT cycles (default 550). Then `link_pdown` is high for one cycle, so the `link_pdown` cycle comes SR_WAIT+1 cycles after the `err_ack` cycle.
- R5: Tier 1 ends with `resend` high for one cycle. The next cycle is normal running: `halt` low and `tier` 0.
- R6: Errors are counted in a window of ERR_WINDOW cycles (default 1000) that opens at the first taken error. An error that brings the count in the open window to T1_THRESH (default 2) selects tier 2. An error taken with the window closed selects tier 1.
- R7: In tier 2, `fast_init_req` stays high, with `fail_ch` holding the error's channel index, until `init_done` is sampled high. Then `resend` follows.
- R8: An error taken within RECENT_HOLD cycles (default 2000) of a tier 2 completion selects tier 3. Tier 3 sets bit `fail_ch` of `degraded_mask`, holds `slow_init_req` until `slow_init_done`, then holds `scrub_req` until `scrub_done`, then sets `svc_req` (sticky) and pulses `resend`.
- R9: With any bit of `degraded_mask` set, an error event sets the sticky `fatal` output. `halt` stays low and `tier` stays 0.
- R10: An accepted store makes `store_ready` low. `store_retire` pulses once, in the cycle after STORE_WIN-1 further cycles (default 16), provided no error event is sampled during the window.
- R11: A `poison_rx` inside a store's window starts recovery (tier 1 when it is alone). That store never retires, and `store_ready` returns high after `resend`.
- R12: While recovering, `tier` shows the selected tier (1 retry, 2 re-init, 3 degrade). It reads 0 whenever `halt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_err | input | 1 | Local CRC error event |
| poison_rx | input | 1 | Poison code received from far end |
| err_ch | input | CH_W | Channel index of the error event |
| outstanding | input | CNT_W | Number of issued, unfinished operations |
| init_done | input | 1 | Fast re-init complete |
| slow_init_done | input | 1 | Slow init of remaining channels complete |
| scrub_done | input | 1 | Scrub pass complete |
| store_valid | input | 1 | Store offered |
| store_ready | output | 1 | Store can be accepted |
| store_retire | output | 1 | Tracked store retired after a quiet window |
| halt | output | 1 | New operations blocked |
| poison_tx | output | 1 | Send poison code downstream |
| err_ack | output | 1 | Send error acknowledge |
| link_pdown | output | 1 | Link treated as powered down |
| resend | output | 1 | Resend pending stores |
| fast_init_req | output | 1 | Fast re-init request for `fail_ch` |
| slow_init_req | output | 1 | Slow init request for surviving channels |
| scrub_req | output | 1 | Scrub pass request |
| fail_ch | output | CH_W | Channel of the last taken error |
| degraded_mask | output | NUM_CH | Channels removed from service |
| svc_req | output | 1 | Service request (sticky) |
| fatal | output | 1 | Error while degraded (sticky) |
| tier | output | 2 | Current recovery tier |

## Verification
The main function is driven with five input patterns. A lone error after a long quiet time must pick the retry tier. A second error soon after that retry must pick re-init, which separates window counting from a plain per-error reaction. An error right after a re-init must pick degrade, which separates the recent-repair hold from the error window. A poison code inside a store's window must show that retire and recovery exclude each other. A final error once degraded must raise the fatal flag without any halt. A behavioural reference model, compared on every clock, pins down the drain length, the self-refresh count and each handshake-driven exit.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [3:0] {
    ST_RUN, ST_DRAIN, ST_POISON, ST_ACK, ST_SREF, ST_PDOWN,
    ST_FINIT, ST_DEGRADE, ST_SLOWI, ST_SCRUB, ST_RESEND
  } lrs_state_e;

  typedef enum logic [1:0] {
    TIER_NONE    = 2'd0,
    TIER_RETRY   = 2'd1,
    TIER_REINIT  = 2'd2,
    TIER_DEGRADE = 2'd3
  } lrs_tier_e;
endpackage

// File: rtl/lrs_err_window.sv
module lrs_err_window
  import lrs_pkg::*;
#(
  parameter int ERR_WINDOW  = 1000,
  parameter int T1_THRESH   = 2,
  parameter int RECENT_HOLD = 2000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      err_take,
  input  logic      reinit_done,
  output lrs_tier_e tier_sel
);
  localparam int WW = $clog2(ERR_WINDOW + 1);
  localparam int HW = $clog2(RECENT_HOLD + 1);
  localparam int CW = $clog2(T1_THRESH + 1);

  logic [WW-1:0] win_tmr;
  logic [CW-1:0] win_cnt;
  logic [CW-1:0] cnt_next;
  logic [HW-1:0] hold_tmr;

  always_comb begin
    if (win_tmr == '0)                 cnt_next = CW'(1);
    else if (win_cnt == CW'(T1_THRESH)) cnt_next = win_cnt;
    else                               cnt_next = win_cnt + 1'b1;
  end

  always_comb begin
    if (hold_tmr != '0)                 tier_sel = TIER_DEGRADE;
    else if (cnt_next >= CW'(T1_THRESH)) tier_sel = TIER_REINIT;
    else                                tier_sel = TIER_RETRY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_tmr  <= '0;
      win_cnt  <= '0;
      hold_tmr <= '0;
    end else begin
      if (err_take) win_cnt <= cnt_next;
      if (err_take && win_tmr == '0) win_tmr <= WW'(ERR_WINDOW);
      else if (win_tmr != '0)        win_tmr <= win_tmr - 1'b1;
      if (reinit_done)          hold_tmr <= HW'(RECENT_HOLD);
      else if (hold_tmr != '0)  hold_tmr <= hold_tmr - 1'b1;
    end
  end

  // R8: a re-init completion must make the very next taken error a degrade
  p_hold_after_reinit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_done |=> (tier_sel == TIER_DEGRADE));
endmodule

// File: rtl/lrs_store_guard.sv
module lrs_store_guard #(
  parameter int STORE_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_valid,
  output logic st_ready,
  input  logic in_run,
  input  logic err_evt,
  input  logic resend,
  output logic store_retire
);
  localparam int TW = $clog2(STORE_WIN + 1);

  logic          pend;
  logic [TW-1:0] tmr;

  assign st_ready     = in_run & ~pend;
  assign store_retire = in_run & pend & (tmr == '0) & ~err_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      tmr  <= '0;
    end else if (resend || store_retire) begin
      pend <= 1'b0;
    end else if (st_valid && st_ready) begin
      pend <= 1'b1;
      tmr  <= TW'(STORE_WIN - 1);
    end else if (in_run && pend && tmr != '0) begin
      tmr  <= tmr - 1'b1;
    end
  end

  p_retire_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    store_retire |=> !store_retire);
  p_accept_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !st_ready);
endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int CH_W    = 3,
  parameter int CNT_W   = 6,
  parameter int SR_WAIT = 550
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_err,
  input  logic              poison_rx,
  input  logic [CH_W-1:0]   err_ch,
  input  logic [CNT_W-1:0]  outstanding,
  input  logic              init_done,
  input  logic              slow_init_done,
  input  logic              scrub_done,
  input  lrs_tier_e         tier_sel,
  output logic              err_evt,
  output logic              err_take,
  output logic              in_run,
  output logic              reinit_done,
  output logic              halt,
  output logic              poison_tx,
  output logic              err_ack,
  output logic              link_pdown,
  output logic              resend,
  output logic              fast_init_req,
  output logic              slow_init_req,
  output logic              scrub_req,
  output logic [CH_W-1:0]   fail_ch,
  output logic [NUM_CH-1:0] degraded_mask,
  output logic              svc_req,
  output logic              fatal,
  output logic [1:0]        tier
);
  localparam int SW = $clog2(SR_WAIT + 1);

  lrs_state_e    state, nxt;
  lrs_tier_e     tier_q;
  logic [SW-1:0] sr_tmr;
  logic          degraded;

  assign degraded      = |degraded_mask;
  assign err_evt       = link_err | poison_rx;
  assign in_run        = (state == ST_RUN);
  assign err_take      = in_run & err_evt & ~degraded;
  assign reinit_done   = (state == ST_FINIT) & init_done;
  assign halt          = ~in_run;
  assign poison_tx     = (state == ST_POISON);
  assign err_ack       = (state == ST_ACK);
  assign link_pdown    = (state == ST_PDOWN);
  assign resend        = (state == ST_RESEND);
  assign fast_init_req = (state == ST_FINIT);
  assign slow_init_req = (state == ST_SLOWI);
  assign scrub_req     = (state == ST_SCRUB);
  assign tier          = tier_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:     if (err_take) nxt = ST_DRAIN;
      ST_DRAIN:   if (outstanding == '0) nxt = ST_POISON;
      ST_POISON:  nxt = ST_ACK;
      ST_ACK:     nxt = ST_SREF;
      ST_SREF:    if (sr_tmr == '0) nxt = ST_PDOWN;
      ST_PDOWN: begin
        if (tier_q == TIER_REINIT)       nxt = ST_FINIT;
        else if (tier_q == TIER_DEGRADE) nxt = ST_DEGRADE;
        else                             nxt = ST_RESEND;
      end
      ST_FINIT:   if (init_done) nxt = ST_RESEND;
      ST_DEGRADE: nxt = ST_SLOWI;
      ST_SLOWI:   if (slow_init_done) nxt = ST_SCRUB;
      ST_SCRUB:   if (scrub_done) nxt = ST_RESEND;
      ST_RESEND:  nxt = ST_RUN;
      default:    nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      tier_q  <= TIER_NONE;
      fail_ch <= '0;
      sr_tmr  <= '0;
      svc_req <= 1'b0;
      fatal   <= 1'b0;
    end else begin
      state <= nxt;
      if (err_take) begin
        tier_q  <= tier_sel;
        fail_ch <= err_ch;
      end else if (state == ST_RESEND) begin
        tier_q  <= TIER_NONE;
      end
      if (state == ST_ACK)                       sr_tmr <= SW'(SR_WAIT - 1);
      else if (state == ST_SREF && sr_tmr != '0) sr_tmr <= sr_tmr - 1'b1;
      if (state == ST_SCRUB && scrub_done) svc_req <= 1'b1;
      if (in_run && err_evt && degraded)   fatal   <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        degraded_mask[g] <= 1'b0;
      else if (state == ST_DEGRADE && fail_ch == CH_W'(g))
        degraded_mask[g] <= 1'b1;
    end
  end

  p_poison_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poison_tx |-> ($past(outstanding) == '0));
  p_ack_follows_poison_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poison_tx |=> err_ack);
  p_actions_under_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (poison_tx || err_ack || link_pdown || resend || fast_init_req || slow_init_req || scrub_req) |-> halt);
  p_tier_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> (tier == 2'd0));
  p_reinit_tier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_init_req |-> (tier == 2'd2));
  p_single_degrade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(degraded_mask));
  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  p_fatal_no_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> !halt);
endmodule

// File: rtl/link_recovery_seq.sv
module link_recovery_seq
  import lrs_pkg::*;
#(
  parameter int NUM_CH      = 5,
  parameter int CNT_W       = 6,
  parameter int SR_WAIT     = 550,
  parameter int ERR_WINDOW  = 1000,
  parameter int T1_THRESH   = 2,
  parameter int RECENT_HOLD = 2000,
  parameter int STORE_WIN   = 16,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_err,
  input  logic              poison_rx,
  input  logic [CH_W-1:0]   err_ch,
  input  logic [CNT_W-1:0]  outstanding,
  input  logic              init_done,
  input  logic              slow_init_done,
  input  logic              scrub_done,
  input  logic              store_valid,
  output logic              store_ready,
  output logic              store_retire,
  output logic              halt,
  output logic              poison_tx,
  output logic              err_ack,
  output logic              link_pdown,
  output logic              resend,
  output logic              fast_init_req,
  output logic              slow_init_req,
  output logic              scrub_req,
  output logic [CH_W-1:0]   fail_ch,
  output logic [NUM_CH-1:0] degraded_mask,
  output logic              svc_req,
  output logic              fatal,
  output logic [1:0]        tier
);
  lrs_tier_e tier_sel;
  logic      err_evt, err_take, in_run, reinit_done;

  lrs_err_window #(
    .ERR_WINDOW(ERR_WINDOW), .T1_THRESH(T1_THRESH), .RECENT_HOLD(RECENT_HOLD)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .err_take(err_take),
    .reinit_done(reinit_done), .tier_sel(tier_sel)
  );

  lrs_store_guard #(.STORE_WIN(STORE_WIN)) u_store (
    .clk(clk), .rst_n(rst_n), .st_valid(store_valid), .st_ready(store_ready),
    .in_run(in_run), .err_evt(err_evt), .resend(resend),
    .store_retire(store_retire)
  );

  lrs_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W), .SR_WAIT(SR_WAIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .link_err(link_err), .poison_rx(poison_rx),
    .err_ch(err_ch), .outstanding(outstanding), .init_done(init_done),
    .slow_init_done(slow_init_done), .scrub_done(scrub_done),
    .tier_sel(tier_sel), .err_evt(err_evt), .err_take(err_take),
    .in_run(in_run), .reinit_done(reinit_done), .halt(halt),
    .poison_tx(poison_tx), .err_ack(err_ack), .link_pdown(link_pdown),
    .resend(resend), .fast_init_req(fast_init_req),
    .slow_init_req(slow_init_req), .scrub_req(scrub_req), .fail_ch(fail_ch),
    .degraded_mask(degraded_mask), .svc_req(svc_req), .fatal(fatal),
    .tier(tier)
  );
endmodule

// File: tb/link_recovery_seq_tb_top.sv
module link_recovery_seq_tb_top;
  localparam int NUM_CH = 5, CNT_W = 6, SRW = 550, WIN = 1000, TH = 2;
  localparam int HOLD = 2000, SWIN = 16, CH_W = 3;
  // reference model phases
  localparam int P_RUN = 0, P_DRAIN = 1, P_POI = 2, P_ACK = 3, P_SREF = 4, P_PD = 5;
  localparam int P_FI = 6, P_DEG = 7, P_SI = 8, P_SC = 9, P_RS = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, link_err = 1'b0, poison_rx = 1'b0, init_done = 1'b0;
  logic slow_init_done = 1'b0, scrub_done = 1'b0, store_valid = 1'b0;
  logic [CH_W-1:0] err_ch = '0;
  logic [CNT_W-1:0] outstanding = '0;
  logic store_ready, store_retire, halt, poison_tx, err_ack, link_pdown, resend;
  logic fast_init_req, slow_init_req, scrub_req, svc_req, fatal;
  logic [CH_W-1:0] fail_ch;
  logic [NUM_CH-1:0] degraded_mask;
  logic [1:0] tier;

  link_recovery_seq dut_i (
    .clk(clk), .rst_n(rst_n), .link_err(link_err), .poison_rx(poison_rx),
    .err_ch(err_ch), .outstanding(outstanding), .init_done(init_done),
    .slow_init_done(slow_init_done), .scrub_done(scrub_done),
    .store_valid(store_valid), .store_ready(store_ready),
    .store_retire(store_retire), .halt(halt), .poison_tx(poison_tx),
    .err_ack(err_ack), .link_pdown(link_pdown), .resend(resend),
    .fast_init_req(fast_init_req), .slow_init_req(slow_init_req),
    .scrub_req(scrub_req), .fail_ch(fail_ch), .degraded_mask(degraded_mask),
    .svc_req(svc_req), .fatal(fatal), .tier(tier)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int ph = P_RUN, mt = 0, mfail = 0, msr = 0, mmask = 0, msvc = 0, mfat = 0;
  int wcnt = 0, wtmr = 0, htmr = 0, spend = 0, stmr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = P_RUN; mt = 0; mfail = 0; msr = 0; mmask = 0; msvc = 0; mfat = 0;
      wcnt = 0; wtmr = 0; htmr = 0; spend = 0; stmr = 0;
    end else begin
      automatic bit evt = link_err | poison_rx;
      automatic bit run = (ph == P_RUN);
      automatic bit take = run && evt && (mmask == 0);
      automatic bit ret = run && spend != 0 && stmr == 0 && !evt;
      automatic bit rdy = run && spend == 0;
      automatic int cn = (wtmr == 0) ? 1 : ((wcnt + 1 > TH) ? TH : wcnt + 1);
      automatic int sel = (htmr > 0) ? 3 : ((cn >= TH) ? 2 : 1);
      automatic int old = ph;
      // store tracking
      if (old == P_RS || ret) spend = 0;
      else if (store_valid && rdy) begin spend = 1; stmr = SWIN - 1; end
      else if (run && spend != 0 && stmr > 0) stmr--;
      // window and recent-repair hold
      if (take) wcnt = cn;
      if (take && wtmr == 0) wtmr = WIN; else if (wtmr > 0) wtmr--;
      if (old == P_FI && init_done) htmr = HOLD; else if (htmr > 0) htmr--;
      if (run && evt && mmask != 0) mfat = 1;
      if (old == P_SC && scrub_done) msvc = 1;
      if (old == P_DEG) mmask = mmask | (1 << mfail);
      if (old == P_ACK) msr = SRW - 1; else if (old == P_SREF && msr > 0) msr--;
      if (take) begin mt = sel; mfail = err_ch; end
      else if (old == P_RS) mt = 0;
      case (old)
        P_RUN:   if (take) ph = P_DRAIN;
        P_DRAIN: if (outstanding == 0) ph = P_POI;
        P_POI:   ph = P_ACK;
        P_ACK:   ph = P_SREF;
        P_SREF:  if (msr == 0 && old == P_SREF && !(ph != P_SREF)) ph = (msr_was_zero(old)) ? P_PD : P_SREF;
        P_PD:    ph = (mt == 2) ? P_FI : ((mt == 3) ? P_DEG : P_RS);
        P_FI:    if (init_done) ph = P_RS;
        P_DEG:   ph = P_SI;
        P_SI:    if (slow_init_done) ph = P_SC;
        P_SC:    if (scrub_done) ph = P_RS;
        default: ph = P_RUN;
      endcase
    end
  end

  // self-refresh exit uses the counter value seen before this edge
  int msr_prev = 0;
  always @(posedge clk) msr_prev <= msr;
  function automatic bit msr_was_zero(input int o);
    return (o == P_SREF) && (msr_prev == 0);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      begin
        automatic bit run = (ph == P_RUN);
        automatic bit evt = link_err | poison_rx;
        chk("R2", "halt", halt, !run);
        chk("R3", "poison_tx", poison_tx, ph == P_POI);
        chk("R3", "err_ack", err_ack, ph == P_ACK);
        chk("R4", "link_pdown", link_pdown, ph == P_PD);
        chk("R5", "resend", resend, ph == P_RS);
        chk("R7", "fast_init_req", fast_init_req, ph == P_FI);
        chk("R7", "fail_ch", fail_ch, mfail);
        chk("R8", "slow_init_req", slow_init_req, ph == P_SI);
        chk("R8", "scrub_req", scrub_req, ph == P_SC);
        chk("R8", "degraded_mask", degraded_mask, mmask);
        chk("R8", "svc_req", svc_req, msvc);
        chk("R9", "fatal", fatal, mfat);
        chk("R12", "tier", tier, mt);
        chk("R10", "store_ready", store_ready, run && spend == 0);
        chk("R10", "store_retire", store_retire, run && spend != 0 && stmr == 0 && !evt);
      end
    end
  end

  // recovery driver with far-end responders
  int max_tier, n_poi, n_ack, ack_c, pd_c, n_ret;
  task automatic run_recovery(input int drain_at);
    int fi = 0, si = 0, sc = 0;
    bit seen = 0;
    max_tier = 0; n_poi = 0; n_ack = 0; ack_c = 0; pd_c = 0; n_ret = 0;
    for (int n = 1; n <= 5000; n++) begin
      @(negedge clk);
      if (halt) seen = 1;
      if (poison_tx) n_poi++;
      if (err_ack) begin n_ack++; ack_c = cyc; end
      if (link_pdown) pd_c = cyc;
      if (store_retire) n_ret++;
      if (int'(tier) > max_tier) max_tier = int'(tier);
      if (n == drain_at) outstanding = '0;
      fi = fast_init_req ? fi + 1 : 0;
      si = slow_init_req ? si + 1 : 0;
      sc = scrub_req ? sc + 1 : 0;
      init_done = (fi == 3);
      slow_init_done = (si == 5);
      scrub_done = (sc == 7);
      if (seen && !halt) break;
    end
    chk("R5", "recovery finished", seen && !halt, 1);
  endtask

  task automatic pulse_err(input bit poison, input int ch);
    @(negedge clk);
    err_ch = CH_W'(ch);
    if (poison) poison_rx = 1'b1; else link_err = 1'b1;
    @(negedge clk);
    link_err = 1'b0; poison_rx = 1'b0;
  endtask

  task automatic issue_store();
    @(negedge clk);
    chk("R10", "ready before store", store_ready, 1);
    store_valid = 1'b1;
    @(negedge clk);
    store_valid = 1'b0;
    chk("R10", "ready while pending", store_ready, 0);
  endtask

  initial begin
    int r;
    repeat (5) @(negedge clk);
    chk("R1", "halt at reset", halt, 0);
    chk("R1", "tier at reset", tier, 0);
    chk("R1", "mask at reset", degraded_mask, 0);
    chk("R1", "ready at reset", store_ready, 1);
    chk("R1", "pulses at reset", {poison_tx, err_ack, link_pdown, resend, fast_init_req,
                                  slow_init_req, scrub_req, svc_req, fatal, store_retire}, 0);
    rst_n = 1'b1;

    // clean store retires once
    issue_store();
    r = 0;
    for (int i = 0; i < SWIN + 3; i++) begin
      @(negedge clk);
      if (store_retire) r++;
    end
    chk("R10", "retire count", r, 1);

    // poison inside the store window: no retire, tier 1
    issue_store();
    repeat (5) @(negedge clk);
    outstanding = 6'd2;
    pulse_err(1'b1, 4);
    run_recovery(3);
    chk("R11", "store retired despite poison", n_ret, 0);
    chk("R11", "tier for lone poison", max_tier, 1);
    chk("R11", "ready after resend", store_ready, 1);
    chk("R3", "poison pulses", n_poi, 1);
    chk("R3", "ack pulses", n_ack, 1);
    chk("R4", "ack to pdown", pd_c - ack_c, SRW + 1);

    // window closed: tier 1 again
    repeat (WIN + 100) @(negedge clk);
    outstanding = 6'd3;
    pulse_err(1'b0, 2);
    run_recovery(4);
    chk("R6", "tier after closed window", max_tier, 1);
    chk("R5", "tier back to zero", tier, 0);

    // second error inside window: tier 2
    repeat (20) @(negedge clk);
    pulse_err(1'b0, 1);
    run_recovery(1);
    chk("R6", "tier for repeat error", max_tier, 2);
    chk("R7", "fail channel", fail_ch, 1);
    chk("R7", "no degrade in tier 2", degraded_mask, 0);

    // error soon after re-init: tier 3
    repeat (20) @(negedge clk);
    pulse_err(1'b0, 3);
    run_recovery(1);
    chk("R8", "tier after recent re-init", max_tier, 3);
    chk("R8", "degraded channel", degraded_mask, 5'b01000);
    chk("R8", "service request", svc_req, 1);

    // error while degraded: fatal, no recovery
    repeat (10) @(negedge clk);
    pulse_err(1'b0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9", "halt while degraded", halt, 0);
      chk("R9", "tier while degraded", tier, 0);
    end
    chk("R9", "fatal flag", fatal, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule